// File: doc/BRIEF.md
# Precise Exception Tracker for a Five-Stage In-Order Pipeline

This block runs beside a five-stage in-order pipeline (fetch, decode, execute, memory, write-back) and makes faults precise. Each stage reports its own fault class. The tracker attaches the fault to the instruction that caused it, carries it down the pipe in a per-stage record of valid bit, exception bit, 3-bit cause and PC, and acts on it only when that instruction reaches write-back. Since instructions reach write-back in program order, the oldest faulting instruction always wins. From the moment a fault is known, the block tells each stage to hold back architectural writes for the faulting instruction and for everything younger than it.

When a trap reaches write-back, the block flushes every stage and redirects fetch to a fixed handler address, both in the same cycle. It also latches the cause and the faulting PC. An external interrupt works differently. Fetch is held, the instructions already in flight finish normally, and once the pipe is empty the block redirects to the handler with an interrupt cause. In that case the saved PC is the one where execution must resume.

Top module: `precise_exc_tracker`

## Requirements
- R1: After a synchronous reset the block is quiet: flush, redirect and fetch hold are low, the write-block vector is all zero, and cause and exception PC are zero.
- R2: An instruction fetched with `fetch_vld_i` high in cycle c that gets a fault from any stage (fetch in c, decode in c+1, execute in c+2, memory in c+3) raises `flush_o` in cycle c+4, with no earlier flush for it.
- R3: Starting in the cycle after a flush, `epc_o` holds the faulting instruction's PC and `cause_o` holds its code: 1 bad fetch address, 2 undefined opcode, 3 arithmetic overflow, 4 bad data address, 5 memory error. If bad data address and memory error are reported together, code 4 wins.
- R4: When one instruction faults in several stages, the code of the earliest stage is kept.
- R5: When several in-flight instructions fault, the oldest one is taken and its PC and cause are saved.
- R6: `wr_block_o[k]` (bit 0 fetch up to bit 4 write-back) is high while the instruction in stage k, or any older instruction, has a known fault. A fault-free flow keeps all bits low.
- R7: A flush discards every younger instruction, so faults they carried never cause a later flush.
- R8: During a flush, `redir_vld_o` is high and `redir_pc_o` equals the handler address, even if a branch redirect is requested in the same cycle. Otherwise a branch request passes through with its target.
- R9: An interrupt request raises `fetch_hold_o` in the same cycle, and fetch offers made while hold is high are ignored. When no instruction remains in flight, the block redirects to the handler without flushing. In the next cycle the cause is 6 and the exception PC is the fetch PC refused in the first hold cycle.
- R10: A branch redirect taken while an interrupt drains replaces the saved resume PC with the branch target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_vld_i | input | 1 | An instruction is fetched this cycle |
| fetch_pc_i | input | AW | PC of the fetched instruction |
| fetch_bad_i | input | 1 | Bad instruction address at fetch |
| dec_illegal_i | input | 1 | Undefined opcode in decode |
| exe_ovf_i | input | 1 | Arithmetic overflow in execute |
| mem_bad_i | input | 1 | Bad data address in memory stage |
| mem_err_i | input | 1 | Memory error in memory stage |
| irq_req_i | input | 1 | External interrupt request (level) |
| br_take_i | input | 1 | Branch redirect request |
| br_target_i | input | AW | Branch target |
| fetch_hold_o | output | 1 | Fetch must not issue new instructions |
| wr_block_o | output | 5 | Per-stage architectural write suppress |
| flush_o | output | 1 | Flush all stages (trap at write-back) |
| redir_vld_o | output | 1 | Fetch redirect valid |
| redir_pc_o | output | AW | Fetch redirect target |
| cause_o | output | 3 | Saved exception cause |
| epc_o | output | AW | Saved exception PC |

## Verification
The fault tests inject a fault for one instruction at each of the four detecting stages. All of them must flush in the same cycle, which shows the fault travels with its instruction and is not acted on where it was found. Two stacked faults on one instruction show whether the first cause is kept. A young fetch fault combined with an older data fault shows age ordering, and the silence after the flush shows that the younger trap was discarded. Interrupt tests run with and without an in-flight branch. Faulty fetch offers made during the hold must leave no trace, and the recorded resume PC tells a fetch PC apart from a branch target.

// File: rtl/exc_trk_pkg.sv
package exc_trk_pkg;
  localparam int NSTG = 5;
  localparam int NFLT = NSTG - 1;
  localparam int CW   = 3;

  typedef enum logic [CW-1:0] {
    C_NONE   = 3'd0,
    C_IFETCH = 3'd1,
    C_OPCODE = 3'd2,
    C_ARITH  = 3'd3,
    C_DADDR  = 3'd4,
    C_MEMERR = 3'd5,
    C_IRQ    = 3'd6
  } cause_e;

  typedef enum logic {ST_RUN, ST_DRAIN} irq_st_e;
endpackage

// File: rtl/exc_trk_slot.sv
module exc_trk_slot
  import exc_trk_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          in_vld,
  input  logic          in_exc,
  input  cause_e        in_cause,
  input  logic [AW-1:0] in_pc,
  input  logic          flt,
  input  cause_e        flt_cause,
  output logic          out_vld,
  output logic          out_exc,
  output cause_e        out_cause,
  output logic [AW-1:0] out_pc
);
  // a cause already carried is never replaced by a later-stage fault
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      out_vld   <= 1'b0;
      out_exc   <= 1'b0;
      out_cause <= C_NONE;
      out_pc    <= '0;
    end else begin
      out_vld <= in_vld;
      out_pc  <= in_pc;
      if (in_vld && in_exc) begin
        out_exc   <= 1'b1;
        out_cause <= in_cause;
      end else if (in_vld && flt) begin
        out_exc   <= 1'b1;
        out_cause <= flt_cause;
      end else begin
        out_exc   <= 1'b0;
        out_cause <= C_NONE;
      end
    end
  end
endmodule

// File: rtl/exc_trk_irq.sv
module exc_trk_irq
  import exc_trk_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          irq_req,
  input  logic          trap,
  input  logic          busy,
  input  logic          br_take,
  input  logic [AW-1:0] br_target,
  input  logic [AW-1:0] fetch_pc,
  output logic          hold,
  output logic          take,
  output logic [AW-1:0] resume_pc
);
  irq_st_e st;

  assign hold = (st == ST_DRAIN) || irq_req;
  assign take = (st == ST_DRAIN) && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_RUN;
      resume_pc <= '0;
    end else begin
      case (st)
        ST_RUN: begin
          if (irq_req && !trap) begin
            st        <= ST_DRAIN;
            resume_pc <= br_take ? br_target : fetch_pc;
          end
        end
        ST_DRAIN: begin
          if (trap || take) st <= ST_RUN;
          else if (br_take) resume_pc <= br_target;
        end
        default: st <= ST_RUN;
      endcase
    end
  end
endmodule

// File: rtl/exc_trk_commit.sv
module exc_trk_commit
  import exc_trk_pkg::*;
#(
  parameter int          AW         = 32,
  parameter logic [AW-1:0] HANDLER_PC = 32'h0000_0180
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          trap,
  input  cause_e        trap_cause,
  input  logic [AW-1:0] trap_pc,
  input  logic          take,
  input  logic [AW-1:0] resume_pc,
  input  logic          br_take,
  input  logic [AW-1:0] br_target,
  output logic          redir_vld,
  output logic [AW-1:0] redir_pc,
  output logic [CW-1:0] cause_q,
  output logic [AW-1:0] epc_q
);
  assign redir_vld = trap || take || br_take;
  assign redir_pc  = (trap || take) ? HANDLER_PC : br_target;

  always_ff @(posedge clk) begin
    if (rst) begin
      cause_q <= C_NONE;
      epc_q   <= '0;
    end else if (trap) begin
      cause_q <= trap_cause;
      epc_q   <= trap_pc;
    end else if (take) begin
      cause_q <= C_IRQ;
      epc_q   <= resume_pc;
    end
  end
endmodule

// File: rtl/precise_exc_tracker.sv
module precise_exc_tracker
  import exc_trk_pkg::*;
#(
  parameter int            AW         = 32,
  parameter logic [AW-1:0] HANDLER_PC = 32'h0000_0180
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            fetch_vld_i,
  input  logic [AW-1:0]   fetch_pc_i,
  input  logic            fetch_bad_i,
  input  logic            dec_illegal_i,
  input  logic            exe_ovf_i,
  input  logic            mem_bad_i,
  input  logic            mem_err_i,
  input  logic            irq_req_i,
  input  logic            br_take_i,
  input  logic [AW-1:0]   br_target_i,
  output logic            fetch_hold_o,
  output logic [NSTG-1:0] wr_block_o,
  output logic            flush_o,
  output logic            redir_vld_o,
  output logic [AW-1:0]   redir_pc_o,
  output logic [CW-1:0]   cause_o,
  output logic [AW-1:0]   epc_o
);
  localparam int LAST = NSTG - 1;

  logic          hold, trap, busy, irq_take;
  logic [AW-1:0] resume_pc;
  logic          f_vld;

  logic          s_vld   [1:LAST];
  logic          s_exc   [1:LAST];
  cause_e        s_cause [1:LAST];
  logic [AW-1:0] s_pc    [1:LAST];

  logic          flt       [0:NFLT-1];
  cause_e        flt_cause [0:NFLT-1];
  logic [NSTG-1:0] blk;

  // fault reported by each detecting stage for the instruction it holds
  always_comb begin
    flt[0]       = fetch_bad_i;
    flt_cause[0] = C_IFETCH;
    flt[1]       = dec_illegal_i;
    flt_cause[1] = C_OPCODE;
    flt[2]       = exe_ovf_i;
    flt_cause[2] = C_ARITH;
    flt[3]       = mem_bad_i || mem_err_i;
    flt_cause[3] = mem_bad_i ? C_DADDR : C_MEMERR;
  end

  assign f_vld = fetch_vld_i && !hold && !trap;
  assign trap  = s_vld[LAST] && s_exc[LAST];

  always_comb begin
    busy = 1'b0;
    for (int k = 1; k <= LAST; k++) busy = busy || s_vld[k];
  end

  for (genvar k = 1; k <= LAST; k++) begin : g_slot
    if (k == 1) begin : g_first
      exc_trk_slot #(.AW(AW)) u_slot (
        .clk(clk), .rst(rst), .clr(trap),
        .in_vld(f_vld), .in_exc(1'b0), .in_cause(C_NONE), .in_pc(fetch_pc_i),
        .flt(flt[0]), .flt_cause(flt_cause[0]),
        .out_vld(s_vld[k]), .out_exc(s_exc[k]), .out_cause(s_cause[k]), .out_pc(s_pc[k])
      );
    end else begin : g_next
      exc_trk_slot #(.AW(AW)) u_slot (
        .clk(clk), .rst(rst), .clr(trap),
        .in_vld(s_vld[k-1]), .in_exc(s_exc[k-1]), .in_cause(s_cause[k-1]), .in_pc(s_pc[k-1]),
        .flt(flt[k-1]), .flt_cause(flt_cause[k-1]),
        .out_vld(s_vld[k]), .out_exc(s_exc[k]), .out_cause(s_cause[k]), .out_pc(s_pc[k])
      );
    end
  end

  // write block propagates from older (higher) stages to younger ones
  assign blk[LAST] = trap;
  for (genvar k = 0; k < LAST; k++) begin : g_blk
    if (k == 0) begin : g_f
      assign blk[k] = blk[k+1] || (f_vld && flt[k]);
    end else begin : g_s
      assign blk[k] = blk[k+1] || (s_vld[k] && (s_exc[k] || flt[k]));
    end
  end

  exc_trk_irq #(.AW(AW)) u_irq (
    .clk(clk), .rst(rst), .irq_req(irq_req_i), .trap(trap), .busy(busy),
    .br_take(br_take_i), .br_target(br_target_i), .fetch_pc(fetch_pc_i),
    .hold(hold), .take(irq_take), .resume_pc(resume_pc)
  );

  exc_trk_commit #(.AW(AW), .HANDLER_PC(HANDLER_PC)) u_commit (
    .clk(clk), .rst(rst), .trap(trap), .trap_cause(s_cause[LAST]), .trap_pc(s_pc[LAST]),
    .take(irq_take), .resume_pc(resume_pc), .br_take(br_take_i), .br_target(br_target_i),
    .redir_vld(redir_vld_o), .redir_pc(redir_pc_o), .cause_q(cause_o), .epc_q(epc_o)
  );

  assign fetch_hold_o = hold;
  assign wr_block_o   = blk;
  assign flush_o      = trap;
endmodule

// File: rtl/exc_trk_chk.sv
module exc_trk_chk
  import exc_trk_pkg::*;
#(
  parameter int            AW         = 32,
  parameter logic [AW-1:0] HANDLER_PC = 32'h0000_0180
) (
  input logic            clk,
  input logic            rst,
  input logic            flush_o,
  input logic            redir_vld_o,
  input logic [AW-1:0]   redir_pc_o,
  input logic [NSTG-1:0] wr_block_o,
  input logic [CW-1:0]   cause_o,
  input logic            fetch_hold_o,
  input logic            irq_take
);
  // R8: a flush always steers fetch to the handler
  assert_flush_to_handler_R8: assert property (@(posedge clk) disable iff (rst)
    flush_o |-> (redir_vld_o && redir_pc_o == HANDLER_PC));

  // R7: a flush empties the pipe, so no flush directly follows it
  assert_flush_single_R7: assert property (@(posedge clk) disable iff (rst)
    flush_o |=> !flush_o);

  // R3: a flush records a fault code
  assert_trap_cause_R3: assert property (@(posedge clk) disable iff (rst)
    flush_o |=> (cause_o != 3'd0 && cause_o != 3'd6));

  // R6: trapping instruction never writes
  assert_trap_blocked_R6: assert property (@(posedge clk) disable iff (rst)
    flush_o |-> wr_block_o[NSTG-1]);

  // R6: a blocked stage implies every younger stage is blocked
  assert_block_order_R6: assert property (@(posedge clk) disable iff (rst)
    (((wr_block_o >> 1) & ~wr_block_o) == '0));

  // R9: interrupt acceptance happens under hold and without flushing
  assert_irq_hold_R9: assert property (@(posedge clk) disable iff (rst)
    irq_take |-> (fetch_hold_o && !flush_o && redir_vld_o));

  // R9: accepted interrupt records the interrupt code
  assert_irq_cause_R9: assert property (@(posedge clk) disable iff (rst)
    irq_take |=> (cause_o == 3'd6));
endmodule

bind precise_exc_tracker exc_trk_chk #(.AW(AW), .HANDLER_PC(HANDLER_PC)) u_chk (
  .clk(clk), .rst(rst), .flush_o(flush_o), .redir_vld_o(redir_vld_o),
  .redir_pc_o(redir_pc_o), .wr_block_o(wr_block_o), .cause_o(cause_o),
  .fetch_hold_o(fetch_hold_o), .irq_take(irq_take)
);

// File: tb/precise_exc_tracker_test.sv
module precise_exc_tracker_test;
  localparam int          AW  = 32;
  localparam logic [31:0] HND = 32'h0000_0180;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fvld = 0, fbad = 0, ill = 0, ovf = 0, mbad = 0, merr = 0, irq = 0, brt = 0;
  logic [AW-1:0] fpc = '0, btgt = '0;
  logic hold, flush, rvld;
  logic [4:0] blk;
  logic [AW-1:0] rpc, epc;
  logic [2:0] cause;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #10 clk = ~clk;

  precise_exc_tracker #(.AW(AW), .HANDLER_PC(HND)) uut (
    .clk(clk), .rst(rst), .fetch_vld_i(fvld), .fetch_pc_i(fpc), .fetch_bad_i(fbad),
    .dec_illegal_i(ill), .exe_ovf_i(ovf), .mem_bad_i(mbad), .mem_err_i(merr),
    .irq_req_i(irq), .br_take_i(brt), .br_target_i(btgt),
    .fetch_hold_o(hold), .wr_block_o(blk), .flush_o(flush), .redir_vld_o(rvld),
    .redir_pc_o(rpc), .cause_o(cause), .epc_o(epc)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // next cycle: all inputs back to idle at the falling edge
  task automatic nxt();
    @(negedge clk);
    fvld = 0; fbad = 0; ill = 0; ovf = 0; mbad = 0; merr = 0; irq = 0; brt = 0;
    fpc = '0; btgt = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) nxt();
  endtask

  task automatic t_reset();
    #1;
    check("R1 flush", flush, 0);
    check("R1 redirect", rvld, 0);
    check("R1 hold", hold, 0);
    check("R1 wr_block", blk, 0);
    check("R1 cause", cause, 0);
    check("R1 epc", epc, 0);
  endtask

  task automatic t_fetch_fault();
    nxt(); fvld = 1; fpc = 32'h100; fbad = 1; #1;
    check("R6 block at fetch", blk, 5'b00001);
    nxt(); #1;
    check("R6 block after decode entry", blk, 5'b00011);
    nxt(); nxt(); #1;
    check("R2 no early flush", flush, 0);
    nxt(); #1;
    check("R2 flush at writeback", flush, 1);
    check("R6 all blocked at trap", blk, 5'b11111);
    check("R8 redirect valid", rvld, 1);
    check("R8 redirect handler", rpc, HND);
    nxt(); #1;
    check("R2 flush one cycle", flush, 0);
    check("R3 cause fetch", cause, 1);
    check("R3 epc fetch", epc, 32'h100);
    idle(3);
  endtask

  task automatic t_clean();
    nxt(); fvld = 1; fpc = 32'h200; #1;
    check("R6 clean block", blk, 0);
    for (int i = 0; i < 5; i++) begin
      nxt(); #1;
      check("R6 clean block", blk, 0);
      check("R2 clean no flush", flush, 0);
    end
  endtask

  // fault on fetched instruction at a given stage offset, expect given code
  task automatic t_stage_fault(input int stg, input logic [31:0] pc, input logic [2:0] code);
    nxt(); fvld = 1; fpc = pc;
    for (int c = 0; c < 5; c++) begin
      if (c > 0) nxt();
      if (c == stg) begin
        case (stg)
          1: ill = 1;
          2: ovf = 1;
          3: merr = 1;
          default: ;
        endcase
      end
      #1;
      if (c < 4) check("R2 no flush before writeback", flush, 0);
      else       check("R2 flush at writeback", flush, 1);
    end
    nxt(); #1;
    check("R3 cause code", cause, code);
    check("R3 epc", epc, pc);
    idle(3);
  endtask

  task automatic t_keep_first();
    nxt(); fvld = 1; fpc = 32'h300; fbad = 1;
    nxt(); nxt(); ovf = 1;
    nxt(); nxt(); #1;
    check("R4 flush", flush, 1);
    nxt(); #1;
    check("R4 earliest cause kept", cause, 1);
    check("R4 epc", epc, 32'h300);
    idle(3);
  endtask

  task automatic t_oldest();
    nxt(); fvld = 1; fpc = 32'h400;
    nxt(); fvld = 1; fpc = 32'h404; fbad = 1;
    nxt();
    nxt(); mbad = 1; merr = 1; #1;
    check("R6 block below memory", blk, 5'b01111);
    nxt(); #1;
    check("R5 flush for older", flush, 1);
    nxt(); #1;
    check("R5 cause of oldest", cause, 4);
    check("R5 epc of oldest", epc, 32'h400);
    check("R7 younger discarded", flush, 0);
    nxt(); #1;
    check("R7 no later flush", flush, 0);
    check("R7 cause unchanged", cause, 4);
    idle(3);
  endtask

  task automatic t_branch();
    nxt(); brt = 1; btgt = 32'h800; #1;
    check("R8 branch passes", rvld, 1);
    check("R8 branch target", rpc, 32'h800);
    check("R8 branch no flush", flush, 0);
    nxt(); fvld = 1; fpc = 32'h500; fbad = 1;
    nxt(); nxt(); nxt();
    nxt(); brt = 1; btgt = 32'h900; #1;
    check("R8 flush with branch", flush, 1);
    check("R8 handler beats branch", rpc, HND);
    idle(4);
  endtask

  task automatic t_irq();
    nxt(); fvld = 1; fpc = 32'h600;
    nxt(); fvld = 1; fpc = 32'h604;
    nxt(); irq = 1; fvld = 1; fpc = 32'h608; #1;
    check("R9 hold raised", hold, 1);
    nxt(); irq = 1; fvld = 1; fpc = 32'h60c; fbad = 1; #1;
    check("R9 hold kept", hold, 1);
    check("R9 ignored fetch not blocked", blk[0], 0);
    nxt(); irq = 1;
    nxt(); irq = 1; #1;
    check("R9 no early accept", rvld, 0);
    nxt(); irq = 1; #1;
    check("R9 accept redirect", rvld, 1);
    check("R9 accept handler", rpc, HND);
    check("R9 accept no flush", flush, 0);
    nxt(); #1;
    check("R9 cause interrupt", cause, 6);
    check("R9 resume pc", epc, 32'h608);
    check("R9 hold released", hold, 0);
    check("R9 ignored fault never traps", flush, 0);
    idle(4);
    #1;
    check("R9 ignored fault stays silent", flush, 0);
  endtask

  task automatic t_irq_branch();
    nxt(); fvld = 1; fpc = 32'h700;
    nxt(); irq = 1; fvld = 1; fpc = 32'h704;
    nxt(); irq = 1; brt = 1; btgt = 32'hA00; #1;
    check("R10 branch passes while draining", rpc, 32'hA00);
    nxt(); irq = 1;
    nxt(); irq = 1;
    nxt(); irq = 1; #1;
    check("R10 accept", rvld, 1);
    nxt(); #1;
    check("R10 resume is branch target", epc, 32'hA00);
    check("R10 cause interrupt", cause, 6);
    idle(3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_fetch_fault();
    t_clean();
    t_stage_fault(1, 32'h210, 3'd2);
    t_stage_fault(2, 32'h220, 3'd3);
    t_stage_fault(3, 32'h230, 3'd5);
    t_keep_first();
    t_oldest();
    t_branch();
    t_irq();
    t_irq_branch();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule